// File: doc/BRIEF.md
# Delegated Interrupt Enable and Pending Registers

This block keeps the machine-level interrupt enable and pending state of a hart. It also presents the supervisor-level views of that state. The supervisor views hold no storage of their own. Each one is a window onto the machine registers, masked by a delegation register. A supervisor bit can be seen and written only while the delegation bit for its source is set. The three sources are software, timer and external, and each has one supervisor-level bit and one machine-level bit.

Requests come from a CSR port made of a write enable, a 12-bit address and write data. Reads are combinational from the current state, so the read data always reflects the present address. A write is accepted on every clock edge where the enable is high. The port has no back-pressure: every request completes in the cycle it is presented. Pending inputs come from the platform timer and the interrupt controller. A separate input lets the interrupt controller raise the supervisor software pending bit.

Top module: `irq_view_regs`

## Requirements
- R1: After reset the delegation, enable and software-pending state are all zero. With all pending inputs low, reads of 0x303, 0x304 and 0x344 return 0.
- R2: The delegation register at 0x303 stores only bits 1 (software), 5 (timer) and 9 (external). Every other bit reads 0.
- R3: The machine enable register at 0x304 stores bits 1, 3, 5, 7, 9 and 11 from a write. Every other bit reads 0.
- R4: The machine pending register at 0x344 works as follows:
  - Bit 1 is stored and written from wdata bit 1.
  - Bits 3, 7 and 11 show the machine software, timer and external inputs.
  - Bits 5 and 9 show the supervisor timer and external inputs.
  - Writes do not change any bit other than bit 1, and all remaining bits read 0.
- R5: A read of the supervisor enable alias at 0x104 returns each of bits 1, 5 and 9 from the machine enable register when that bit is delegated, and 0 when it is not. All other bits read 0.
- R6: A write to 0x104 updates machine enable bit 1, 5 or 9 only when that bit is delegated at the time of the write. No other machine enable bit changes.
- R7: A read of the supervisor pending alias at 0x144 returns each of bits 1, 5 and 9 from the machine pending value when that bit is delegated, and 0 when it is not. All other bits read 0.
- R8: A write to 0x144 can change only pending bit 1, and only when software interrupts are delegated (delegation bit 1 set).
- R9: When the supervisor software set input is high, pending bit 1 becomes 1 at that clock edge. This holds even if a write of 0 to 0x344 or 0x144 happens in the same cycle. The new value is visible on the next cycle's read.
- R10: Writes take effect at the clock edge where the write enable is high. An address outside the five decoded ones reads 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wen | input | 1 | Write enable for the current address |
| csr_addr | input | ADDR_W | CSR address, used for both read and write |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for csr_addr |
| irq_m_soft | input | 1 | Machine software pending level |
| irq_m_timer | input | 1 | Machine timer pending level |
| irq_m_ext | input | 1 | Machine external pending level |
| irq_s_timer | input | 1 | Supervisor timer pending level |
| irq_s_ext | input | 1 | Supervisor external pending level |
| irq_s_soft_set | input | 1 | Interrupt-controller set of supervisor software pending |

## Verification
The assertions check the masking on every cycle:
- unimplemented bits of the delegation, enable and alias reads are zero;
- undelegated bits are hidden in both supervisor views;
- a supervisor enable write never moves an undelegated bit;
- the software set input always leaves the pending bit high.

Other behaviour appears only in the bench's scenarios:
- whether delegated writes land in the right bits;
- whether machine writes are filtered correctly;
- how the pending inputs map to bit positions;
- how a write and a set in the same cycle resolve.

A cycle-by-cycle model in the bench checks these scenarios against the read data.

// File: rtl/irq_view_pkg.sv
package irq_view_pkg;
  localparam int NSRC = 3;  // 0 software, 1 timer, 2 external

  localparam logic [11:0] A_MDELEG = 12'h303;
  localparam logic [11:0] A_MEN    = 12'h304;
  localparam logic [11:0] A_MPEND  = 12'h344;
  localparam logic [11:0] A_SEN    = 12'h104;
  localparam logic [11:0] A_SPEND  = 12'h144;

  typedef struct packed {
    logic mdeleg;
    logic men;
    logic mpend;
    logic sen;
    logic spend;
  } csr_sel_t;

  // supervisor-level bit of source s, machine-level bit of source s
  function automatic int sup_pos(int s);
    return 1 + 4 * s;
  endfunction

  function automatic int mach_pos(int s);
    return 3 + 4 * s;
  endfunction
endpackage

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
  import irq_view_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_t          sel,
  output csr_sel_t          wr
);
  always_comb begin
    sel.mdeleg = (addr == ADDR_W'(A_MDELEG));
    sel.men    = (addr == ADDR_W'(A_MEN));
    sel.mpend  = (addr == ADDR_W'(A_MPEND));
    sel.sen    = (addr == ADDR_W'(A_SEN));
    sel.spend  = (addr == ADDR_W'(A_SPEND));
    wr         = wen ? sel : '0;
  end
endmodule

// File: rtl/irq_deleg_reg.sv
module irq_deleg_reg
  import irq_view_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] deleg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  deleg_q <= '0;
    else if (wr) deleg_q <= wbits;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_view_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_m,
  input  logic            wr_s,
  input  logic [NSRC-1:0] deleg,
  input  logic [NSRC-1:0] wsup,
  input  logic [NSRC-1:0] wmach,
  output logic [NSRC-1:0] sup_en_q,
  output logic [NSRC-1:0] mach_en_q
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    // supervisor bit: machine write always, alias write only when delegated
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     sup_en_q[s] <= 1'b0;
      else if (wr_m)                  sup_en_q[s] <= wsup[s];
      else if (wr_s && deleg[s])      sup_en_q[s] <= wsup[s];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mach_en_q[s] <= 1'b0;
      else if (wr_m)  mach_en_q[s] <= wmach[s];
    end
  end
endmodule

// File: rtl/irq_soft_pend.sv
module irq_soft_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_m,
  input  logic wr_s,
  input  logic deleg_soft,
  input  logic wbit,
  input  logic set_in,
  output logic pend_q
);
  logic nxt;
  always_comb begin
    nxt = pend_q;
    if (wr_m || (wr_s && deleg_soft)) nxt = wbit;
    if (set_in)                       nxt = 1'b1;  // controller set dominates
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= nxt;
  end
endmodule

// File: rtl/irq_view_regs.sv
module irq_view_regs
  import irq_view_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wen,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              irq_m_soft,
  input  logic              irq_m_timer,
  input  logic              irq_m_ext,
  input  logic              irq_s_timer,
  input  logic              irq_s_ext,
  input  logic              irq_s_soft_set
);
  csr_sel_t        sel, wr;
  logic [NSRC-1:0] wsup, wmach;
  logic [NSRC-1:0] deleg_q, sup_en_q, mach_en_q;
  logic            ssip_q;
  logic [NSRC-1:0] sup_pend, mach_pend;
  logic [XLEN-1:0] deleg_vec, en_vec, pend_vec;

  irq_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wen(csr_wen), .addr(csr_addr), .sel(sel), .wr(wr)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_gather
    assign wsup[s]  = csr_wdata[sup_pos(s)];
    assign wmach[s] = csr_wdata[mach_pos(s)];
  end

  irq_deleg_reg u_deleg (
    .clk(clk), .rst_n(rst_n), .wr(wr.mdeleg), .wbits(wsup), .deleg_q(deleg_q)
  );

  irq_enable_reg u_en (
    .clk(clk), .rst_n(rst_n), .wr_m(wr.men), .wr_s(wr.sen),
    .deleg(deleg_q), .wsup(wsup), .wmach(wmach),
    .sup_en_q(sup_en_q), .mach_en_q(mach_en_q)
  );

  irq_soft_pend u_ssip (
    .clk(clk), .rst_n(rst_n), .wr_m(wr.mpend), .wr_s(wr.spend),
    .deleg_soft(deleg_q[0]), .wbit(csr_wdata[sup_pos(0)]),
    .set_in(irq_s_soft_set), .pend_q(ssip_q)
  );

  assign sup_pend  = {irq_s_ext, irq_s_timer, ssip_q};
  assign mach_pend = {irq_m_ext, irq_m_timer, irq_m_soft};

  always_comb begin
    deleg_vec = '0;
    en_vec    = '0;
    pend_vec  = '0;
    for (int s = 0; s < NSRC; s++) begin
      deleg_vec[sup_pos(s)]  = deleg_q[s];
      en_vec[sup_pos(s)]     = sup_en_q[s];
      en_vec[mach_pos(s)]    = mach_en_q[s];
      pend_vec[sup_pos(s)]   = sup_pend[s];
      pend_vec[mach_pos(s)]  = mach_pend[s];
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (sel.mdeleg) csr_rdata = deleg_vec;
    if (sel.men)    csr_rdata = en_vec;
    if (sel.mpend)  csr_rdata = pend_vec;
    if (sel.sen)    csr_rdata = en_vec & deleg_vec;
    if (sel.spend)  csr_rdata = pend_vec & deleg_vec;
  end
endmodule

// File: rtl/irq_view_chk.sv
module irq_view_chk
  import irq_view_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_wen,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              irq_s_soft_set,
  input logic [NSRC-1:0]   deleg_q,
  input logic [NSRC-1:0]   sup_en_q,
  input logic              ssip_q
);
  localparam logic [XLEN-1:0] DMASK = XLEN'(12'h222);
  localparam logic [XLEN-1:0] EMASK = XLEN'(12'hAAA);
  logic [XLEN-1:0] dvec;
  always_comb begin
    dvec = '0;
    for (int s = 0; s < NSRC; s++) dvec[sup_pos(s)] = deleg_q[s];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (deleg_q == '0 && sup_en_q == '0 && !ssip_q));

  assert_deleg_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_W'(A_MDELEG)) |-> ((csr_rdata & ~DMASK) == '0));

  assert_men_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_W'(A_MEN)) |-> ((csr_rdata & ~EMASK) == '0));

  assert_sen_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_W'(A_SEN)) |-> ((csr_rdata & ~dvec) == '0));

  assert_spend_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_W'(A_SPEND)) |-> ((csr_rdata & ~dvec) == '0));

  for (genvar s = 0; s < NSRC; s++) begin : g_blk
    assert_sen_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wen && csr_addr == ADDR_W'(A_SEN) && !deleg_q[s]) |=> $stable(sup_en_q[s]));
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_s_soft_set |=> ssip_q);
endmodule

bind irq_view_regs irq_view_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_wen(csr_wen), .csr_addr(csr_addr),
  .csr_rdata(csr_rdata), .irq_s_soft_set(irq_s_soft_set),
  .deleg_q(deleg_q), .sup_en_q(sup_en_q), .ssip_q(ssip_q)
);

// File: tb/irq_view_regs_test.sv
module irq_view_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wen = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        irq_m_soft = 0, irq_m_timer = 0, irq_m_ext = 0;
  logic        irq_s_timer = 0, irq_s_ext = 0, irq_s_soft_set = 0;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  logic [63:0] m_deleg = '0, m_en = '0;
  logic        m_ssip = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_view_regs uut (
    .clk(clk), .rst_n(rst_n), .csr_wen(csr_wen), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_m_soft(irq_m_soft), .irq_m_timer(irq_m_timer), .irq_m_ext(irq_m_ext),
    .irq_s_timer(irq_s_timer), .irq_s_ext(irq_s_ext), .irq_s_soft_set(irq_s_soft_set)
  );

  function automatic logic [63:0] pend_now();
    logic [63:0] p = '0;
    p[1] = m_ssip;      p[3] = irq_m_soft;  p[5] = irq_s_timer;
    p[7] = irq_m_timer; p[9] = irq_s_ext;   p[11] = irq_m_ext;
    return p;
  endfunction

  function automatic logic [63:0] expect_read(logic [11:0] a);
    case (a)
      12'h303: return m_deleg;
      12'h304: return m_en;
      12'h344: return pend_now();
      12'h104: return m_en & m_deleg;
      12'h144: return pend_now() & m_deleg;
      default: return '0;
    endcase
  endfunction

  function automatic string addr_tag(logic [11:0] a);
    case (a)
      12'h303: return "R2";
      12'h304: return "R3";
      12'h344: return "R4";
      12'h104: return "R5";
      12'h144: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input logic w, input logic [11:0] a, input logic [63:0] d,
                      input logic set, input logic [4:0] irqs, input string tag);
    logic [63:0] exp;
    @(negedge clk);
    csr_wen = w; csr_addr = a; csr_wdata = d; irq_s_soft_set = set;
    {irq_s_ext, irq_s_timer, irq_m_ext, irq_m_timer, irq_m_soft} = irqs;
    #1;
    exp = expect_read(a);
    vectors++;
    if (csr_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", (tag == "") ? addr_tag(a) : tag,
               a, csr_rdata, exp);
    end
    @(posedge clk);
    if (w) begin
      case (a)
        12'h303: m_deleg = d & 64'h222;
        12'h304: m_en = d & 64'hAAA;
        12'h104: m_en = (m_en & ~m_deleg) | (d & m_deleg);
        12'h344: m_ssip = d[1];
        12'h144: if (m_deleg[1]) m_ssip = d[1];
        default: ;
      endcase
    end
    if (set) m_ssip = 1'b1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [6];
    addrs = '{12'h303, 12'h304, 12'h344, 12'h104, 12'h144, 12'h105};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset values
    step(0, 12'h303, '0, 0, '0, "R1");
    step(0, 12'h304, '0, 0, '0, "R1");
    step(0, 12'h344, '0, 0, '0, "R1");
    // R3 machine enable write filter
    step(1, 12'h304, '1, 0, '0, "R3");
    step(0, 12'h304, '0, 0, '0, "R3");
    // R2 delegation write filter
    step(1, 12'h303, '1, 0, '0, "R2");
    step(0, 12'h303, '0, 0, '0, "R2");
    step(0, 12'h104, '0, 0, '0, "R5");
    // R6 alias write with only timer delegated
    step(1, 12'h303, 64'h20, 0, '0, "R6");
    step(1, 12'h104, '0, 0, '0, "R6");
    step(0, 12'h304, '0, 0, '0, "R6");
    // R8 pending alias write blocked when software not delegated
    step(1, 12'h144, '1, 0, 5'b11111, "R8");
    step(0, 12'h344, '0, 0, 5'b11111, "R8");
    // R4 machine pending write, inputs reflected
    step(1, 12'h344, '1, 0, 5'b10101, "R4");
    step(0, 12'h344, '0, 0, 5'b01010, "R4");
    // R9 set wins over same-cycle clear
    step(1, 12'h303, 64'h222, 0, '0, "R9");
    step(1, 12'h144, '0, 1, '0, "R9");
    step(0, 12'h144, '0, 0, '0, "R9");
    step(1, 12'h344, '0, 1, '0, "R9");
    step(0, 12'h344, '0, 0, '0, "R9");
    // R10 unmapped address
    step(1, 12'h105, '1, 0, '0, "R10");
    step(0, 12'h304, '0, 0, '0, "R10");
    // mixed traffic compared every cycle
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 2) == 0, addrs[$urandom % 6], {$urandom, $urandom},
           ($urandom % 8) == 0, 5'($urandom), "");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule